// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the address stream for instructions that load or store a group of registers in one go. A start pulse supplies a 32-bit base address, a 16-bit mask of selected registers, one of four addressing modes and a writeback flag. The sequencer then presents one word access per selected register, giving the register index and the byte address for it. The memory side grants each access with a ready signal.

When the last access has been granted, the block raises a one-cycle done pulse. Together with that pulse it gives the updated base value and whether the base register should take it. Loads and stores use the same address stream; the data path belongs to the surrounding core.

Registers always go out in ascending index order, so the lowest-numbered register sits at the lowest address in every mode. Decrementing modes therefore compute their lowest address first and then walk upward.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `req_o`, `done_o`, `busy_o` and `wb_valid_o` are low.
- R2: `mode_i` encodes 0 = increment-after, 1 = increment-before, 2 = decrement-after, 3 = decrement-before. With n selected registers, the first access address is base, base+4, base-4n+4 or base-4n for these modes, presented the cycle after `start_i` is accepted.
- R3: Accesses go out in ascending register index, one per selected bit (bit i of `reg_list_i` selects register i). Each address is 4 above the one before it.
- R4: The sequencer advances only on a cycle where `req_o` and `mem_ready_i` are both high. While `mem_ready_i` is low, `req_o`, `reg_idx_o` and `addr_o` hold.
- R5: `done_o` is high for exactly one cycle, in the cycle after the last access is granted. `busy_o` is low in the cycle after that.
- R6: During `done_o`, `wb_base_o` is base+4n for the increment modes and base-4n for the decrement modes, and `wb_valid_o` equals the captured writeback flag.
- R7: An empty register list produces no access. `done_o` rises in the cycle after start, with `wb_base_o` equal to the base.
- R8: `start_i` is ignored while `busy_o` is high. The sequence in progress and its writeback value are unaffected.
- R9: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (accepted when idle) |
| base_i | input | 32 | Base byte address |
| reg_list_i | input | 16 | Selected registers, bit i = register i |
| mode_i | input | 2 | Addressing mode |
| wb_en_i | input | 1 | Request base writeback |
| mem_ready_i | input | 1 | Memory side accepts the current access |
| req_o | output | 1 | Access valid |
| reg_idx_o | output | 4 | Register index of the current access |
| addr_o | output | 32 | Word address of the current access |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Base register should be updated |
| wb_base_o | output | 32 | Updated base value |
| busy_o | output | 1 | Transfer in progress |

## Verification
The hardest case to reach is a second start request that arrives mid-sequence, at the same moment as stalled or granted accesses. It must leave both the address stream and the pending writeback value untouched. The bench pulses `start_i` with a different base and a full register list during the first access of a running transfer. It does this once on a single-register list, where the grant also ends the sequence, and once on a stalled decrement sequence. It then checks that every later address and the final base still follow the original request. Wrap-around below address zero is reached by combining a full list, a decrement-before mode and a base of 8.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'd0,
    MODE_INC_BEFORE = 2'd1,
    MODE_DEC_AFTER  = 2'd2,
    MODE_DEC_BEFORE = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bxs_popcount.sv
module bxs_popcount #(
  parameter int unsigned VEC_W = 16,
  localparam int unsigned CNT_W = $clog2(VEC_W + 1)
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < VEC_W; i++) begin
      cnt_o = cnt_o + CNT_W'(vec_i[i]);
    end
  end
endmodule

// File: rtl/bxs_lowest_idx.sv
module bxs_lowest_idx #(
  parameter int unsigned VEC_W = 16,
  localparam int unsigned IDX_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // scan downward so the last hit is the lowest set bit
  always_comb begin
    idx_o = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/bxs_addr_gen.sv
module bxs_addr_gen
  import blk_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] wb_base_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] low_end;
  xfer_mode_e        mode;

  assign mode = xfer_mode_e'(mode_i);
  assign span = ADDR_W'(cnt_i) * STEP;
  assign low_end = base_i - span;

  always_comb begin
    unique case (mode)
      MODE_INC_AFTER:  first_addr_o = base_i;
      MODE_INC_BEFORE: first_addr_o = base_i + STEP;
      MODE_DEC_AFTER:  first_addr_o = low_end + STEP;
      default:         first_addr_o = low_end;
    endcase
  end

  assign wb_base_o = mode_i[1] ? low_end : base_i + span;
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LIST_W     = 16,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned IDX_W     = $clog2(LIST_W),
  localparam int unsigned CNT_W     = $clog2(LIST_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIST_W-1:0] reg_list_i,
  input  logic [1:0]        mode_i,
  input  logic              wb_en_i,
  input  logic              mem_ready_i,
  output logic              req_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_base_o,
  output logic              busy_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  seq_state_e        state_q;
  logic [LIST_W-1:0] pending_q;
  logic [LIST_W-1:0] pending_rest;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wb_base_q;
  logic              wb_en_q;
  logic [CNT_W-1:0]  sel_cnt;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] wb_calc;
  logic              pend_any;
  logic              accept;
  logic              advance;

  bxs_popcount #(.VEC_W(LIST_W)) u_cnt (
    .vec_i (reg_list_i),
    .cnt_o (sel_cnt)
  );

  bxs_addr_gen #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_addr (
    .base_i       (base_i),
    .cnt_i        (sel_cnt),
    .mode_i       (mode_i),
    .first_addr_o (first_addr),
    .wb_base_o    (wb_calc)
  );

  bxs_lowest_idx #(.VEC_W(LIST_W)) u_pick (
    .vec_i (pending_q),
    .idx_o (reg_idx_o),
    .any_o (pend_any)
  );

  assign accept       = start_i && (state_q == ST_IDLE);
  assign advance      = (state_q == ST_RUN) && mem_ready_i;
  assign pending_rest = pending_q & (pending_q - LIST_W'(1));  // drop lowest set bit

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
      addr_q    <= '0;
      wb_base_q <= '0;
      wb_en_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          pending_q <= reg_list_i;
          addr_q    <= first_addr;
          wb_base_q <= wb_calc;
          wb_en_q   <= wb_en_i;
          state_q   <= (reg_list_i == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: if (advance) begin
          pending_q <= pending_rest;
          addr_q    <= addr_q + STEP;
          if (pending_rest == '0) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o      = (state_q == ST_RUN);
  assign addr_o     = addr_q;
  assign done_o     = (state_q == ST_DONE);
  assign wb_valid_o = done_o && wb_en_q;
  assign wb_base_o  = wb_base_q;
  assign busy_o     = (state_q != ST_IDLE);

  assert_hold_on_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !mem_ready_i |=> req_o && $stable(addr_o) && $stable(reg_idx_o));

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && mem_ready_i |=> !req_o || (addr_o == $past(addr_o) + STEP));

  assert_idx_ascends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && mem_ready_i |=> !req_o || (reg_idx_o > $past(reg_idx_o)));

  assert_req_has_reg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> pend_any);

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  assert_done_excl_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && req_o));

  assert_empty_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (reg_list_i == '0) |=> done_o && !req_o);

  assert_busy_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && req_o && !mem_ready_i |=> $stable(addr_o) && $stable(wb_base_o));
endmodule

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reg_list_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wb_en_i = 1'b0;
  logic        mem_ready_i = 1'b0;
  logic        req_o;
  logic [3:0]  reg_idx_o;
  logic [31:0] addr_o;
  logic        done_o;
  logic        wb_valid_o;
  logic [31:0] wb_base_o;
  logic        busy_o;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  blk_xfer_seq u_dut (
    .clk_i, .rst_ni, .start_i, .base_i, .reg_list_i, .mode_i, .wb_en_i,
    .mem_ready_i, .req_o, .reg_idx_o, .addr_o, .done_o, .wb_valid_o,
    .wb_base_o, .busy_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge with the block idle.
  task automatic run_xfer(input logic [31:0] base, input logic [15:0] list,
                          input logic [1:0] mode, input logic wb,
                          input logic [15:0] stall_mask, input logic poke,
                          input string addr_tag, input string wb_tag);
    int n = 0;
    int k = 0;
    logic [31:0] addr;
    logic [31:0] wb_exp;
    for (int i = 0; i < 16; i++) n += int'(list[i]);
    case (mode)
      2'd0: addr = base;
      2'd1: addr = base + 32'd4;
      2'd2: addr = base - 32'(4 * n) + 32'd4;
      default: addr = base - 32'(4 * n);
    endcase
    wb_exp = mode[1] ? base - 32'(4 * n) : base + 32'(4 * n);
    start_i = 1'b1; base_i = base; reg_list_i = list; mode_i = mode; wb_en_i = wb;
    @(negedge clk_i);
    start_i = 1'b0; base_i = ~base; reg_list_i = ~list; wb_en_i = ~wb;
    for (int i = 0; i < 16; i++) begin
      if (list[i]) begin
        if (stall_mask[k]) begin
          for (int s = 0; s < 2; s++) begin
            mem_ready_i = 1'b0;
            check("R4 req held", 32'(req_o), 32'd1);
            check("R4 idx held", 32'(reg_idx_o), 32'(i));
            check("R4 addr held", addr_o, addr);
            @(negedge clk_i);
          end
        end
        check(k == 0 ? "R2 first req" : "R3 req", 32'(req_o), 32'd1);
        check("R3 idx", 32'(reg_idx_o), 32'(i));
        check(k == 0 ? "R2 first addr" : addr_tag, addr_o, addr);
        if (poke && k == 0) begin
          start_i = 1'b1; base_i = 32'hDEAD_0000; reg_list_i = 16'hFFFF; mode_i = 2'd0;
        end
        mem_ready_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0; mode_i = mode; mem_ready_i = 1'b0;
        addr = addr + 32'd4;
        k++;
      end
    end
    check(n == 0 ? "R7 done after empty" : "R5 done", 32'(done_o), 32'd1);
    check("R5 no req at done", 32'(req_o), 32'd0);
    check(wb_tag, wb_base_o, wb_exp);
    check("R6 wb valid", 32'(wb_valid_o), 32'(wb));
    @(negedge clk_i);
    check("R5 done one cycle", 32'(done_o), 32'd0);
    check("R5 idle after done", 32'(busy_o), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 req", 32'(req_o), 32'd0);
    check("R1 done", 32'(done_o), 32'd0);
    check("R1 busy", 32'(busy_o), 32'd0);
    check("R1 wb valid", 32'(wb_valid_o), 32'd0);
  endtask

  task automatic t_idle_ready();
    // ready with no transfer must not start anything (R4)
    mem_ready_i = 1'b1;
    @(negedge clk_i);
    mem_ready_i = 1'b0;
    check("R4 no req when idle", 32'(req_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_idle_ready();
    run_xfer(32'h0000_1000, 16'h0013, 2'd0, 1'b1, 16'h0000, 1'b0, "R3 addr", "R6 wb ia");
    run_xfer(32'h0000_1000, 16'h0013, 2'd1, 1'b0, 16'h0002, 1'b0, "R3 addr", "R6 wb ib");
    run_xfer(32'h0000_2000, 16'h8421, 2'd2, 1'b1, 16'h0005, 1'b0, "R3 addr", "R6 wb da");
    run_xfer(32'h0000_2000, 16'h8421, 2'd3, 1'b1, 16'h0000, 1'b0, "R3 addr", "R6 wb db");
    run_xfer(32'h0000_0008, 16'hFFFF, 2'd3, 1'b1, 16'h8001, 1'b0, "R9 wrapped addr", "R9 wrapped wb");
    run_xfer(32'hFFFF_FFF8, 16'h0007, 2'd0, 1'b1, 16'h0000, 1'b0, "R9 wrapped addr", "R9 wrapped wb");
    run_xfer(32'h0000_1234, 16'h0000, 2'd3, 1'b1, 16'h0000, 1'b0, "R3 addr", "R7 base unchanged");
    run_xfer(32'h0000_4000, 16'h8000, 2'd0, 1'b1, 16'h0000, 1'b1, "R8 addr", "R8 wb after poke");
    run_xfer(32'h0000_3000, 16'h0C30, 2'd3, 1'b0, 16'h0006, 1'b1, "R8 addr", "R8 wb after poke");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule